// File: doc/BRIEF.md
# Circular playback address sequencer

This block walks a row address through a circular message store during playback. A segment runs from a start row to an end row, and both rows are played. The storage engine sends a one-cycle pulse each time it finishes a row, and the address then moves on by one. When the address passes the top row, it lands on the first row above a reserved low region, never on row zero. An end row below the start row is therefore legal and means "wrap, then stop".

One further start/end pair can be loaded while a segment plays. When the running segment finishes, the address jumps straight to the queued start row in the same clock edge, with no idle cycle. The chain ends when a segment finishes and nothing is queued. The block then drops busy, raises ready and gives a single interrupt pulse. A mode input picks the stop rule: either the end row, or the first end-of-message marker from the storage engine.

All pins are plain control and status lines. The preload path has no back-pressure: it always accepts, and a newer pair replaces an older queued one. No valid/ready handshake is used, because there is no data stream that could be held off.

Top module: `play_addr_seq`

## Requirements
- R1: After reset, cur_addr is 0x000, busy, seg_done, irq and queued are 0, and ready is 1.
- R2: A start_req seen while idle loads cur_addr with start_addr and the end row with end_addr, and busy is 1 after that edge. A start_req seen while busy has no effect on cur_addr or busy. While idle, cur_addr holds its value.
- R3: While busy and not ending, each row_adv pulse raises cur_addr by exactly one, unless cur_addr is at the top row.
- R4: Row addresses are 11 bits wide, and the top row is 0x7FF. A row_adv at 0x7FF moves cur_addr to 0x010, so rows 0x000 to 0x00F are never reached by the wrap.
- R5: With stop_on_eom = 0, a segment ends on the row_adv pulse that arrives while cur_addr equals the end row, so the end row is played. An end row below the start row wraps first and then ends.
- R6: With stop_on_eom = 0, an end row below both the start row and 0x010 is never matched, and busy stays 1 however many row_adv pulses arrive.
- R7: With stop_on_eom = 1, the end row is ignored. cur_addr keeps advancing past it, and the segment ends on the first eom pulse seen while busy.
- R8: A preload_stb stores preload_start/preload_end and sets queued to 1. A second strobe before the pair is used replaces it. queued stays 1 until the pair is consumed. A strobe on the same edge as a consumption leaves the new pair queued.
- R9: When a segment ends and a pair is queued, the next cycle shows cur_addr equal to the queued start, busy still 1, seg_done 1, irq 0 and queued 0. The queued end row then governs the stop.
- R10: When a segment ends and nothing is queued, the next cycle shows busy 0, ready 1, seg_done 1 and irq 1. irq lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Begin a segment when idle |
| start_addr | input | 11 | First row of the started segment |
| end_addr | input | 11 | Last row of the started segment |
| preload_stb | input | 1 | Queue the next segment pair |
| preload_start | input | 11 | First row of the queued segment |
| preload_end | input | 11 | Last row of the queued segment |
| row_adv | input | 1 | One-cycle pulse: storage engine finished a row |
| eom | input | 1 | End-of-message marker pulse |
| stop_on_eom | input | 1 | 0: stop at end row, 1: stop at marker |
| cur_addr | output | 11 | Current row address |
| busy | output | 1 | Playback in progress |
| ready | output | 1 | Idle and able to accept start_req |
| seg_done | output | 1 | One-cycle pulse at each segment end |
| irq | output | 1 | One-cycle pulse when the whole chain ends |
| queued | output | 1 | A preloaded pair is waiting |

## Verification
The hardest state to reach from the pins is a run that never ends, because the address has to go round the whole circle. The stimulus starts just below the top row with an end row inside the reserved region. It then feeds more row pulses than the circle holds, so the wrap is crossed twice without a match. The run is then ended through the marker mode. Seamless chaining is reached by loading two pairs, where the second overwrites the first, before the running segment's last row, and then checking that the second pair takes effect on the exact edge.

// File: rtl/play_seq_pkg.sv
`timescale 1ns/1ps
package play_seq_pkg;
  localparam int unsigned DEF_ROW_W     = 11;
  localparam int unsigned DEF_WRAP_BASE = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/row_stepper.sv
`timescale 1ns/1ps
module row_stepper #(
  parameter int unsigned ROW_W     = play_seq_pkg::DEF_ROW_W,
  parameter int unsigned WRAP_BASE = play_seq_pkg::DEF_WRAP_BASE
) (
  input  logic [ROW_W-1:0] cur,
  output logic [ROW_W-1:0] nxt
);
  localparam logic [ROW_W-1:0] TOP_ROW  = '1;
  localparam logic [ROW_W-1:0] WRAP_ROW = ROW_W'(WRAP_BASE);

  always_comb begin
    if (cur == TOP_ROW) nxt = WRAP_ROW;
    else                nxt = cur + 1'b1;
  end

  // R4
  always_comb begin
    wrap_floor_chk: assert ((cur < WRAP_ROW) || (nxt >= WRAP_ROW));
  end
endmodule

// File: rtl/pair_slot.sv
`timescale 1ns/1ps
module pair_slot #(
  parameter int unsigned ROW_W = play_seq_pkg::DEF_ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             take,
  input  logic [ROW_W-1:0] in_first,
  input  logic [ROW_W-1:0] in_last,
  output logic [ROW_W-1:0] out_first,
  output logic [ROW_W-1:0] out_last,
  output logic             full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      out_first <= '0;
      out_last  <= '0;
    end else begin
      if (load) begin
        full      <= 1'b1;
        out_first <= in_first;
        out_last  <= in_last;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  // R8
  load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> full);
  // R8
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |=> !full);
endmodule

// File: rtl/seg_control.sv
`timescale 1ns/1ps
module seg_control #(
  parameter int unsigned ROW_W     = play_seq_pkg::DEF_ROW_W,
  parameter int unsigned WRAP_BASE = play_seq_pkg::DEF_WRAP_BASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [ROW_W-1:0] start_addr,
  input  logic [ROW_W-1:0] end_addr,
  input  logic             row_adv,
  input  logic             eom,
  input  logic             stop_on_eom,
  input  logic             q_full,
  input  logic [ROW_W-1:0] q_first,
  input  logic [ROW_W-1:0] q_last,
  input  logic [ROW_W-1:0] nxt_addr,
  output logic [ROW_W-1:0] cur_addr,
  output logic             busy,
  output logic             take,
  output logic             seg_done,
  output logic             irq
);
  import play_seq_pkg::*;

  localparam logic [ROW_W-1:0] TOP_ROW  = '1;
  localparam logic [ROW_W-1:0] WRAP_ROW = ROW_W'(WRAP_BASE);

  run_state_e       state;
  logic [ROW_W-1:0] end_r;
  logic             ending;

  assign busy   = (state == ST_RUN);
  assign ending = busy && (stop_on_eom ? eom : (row_adv && (cur_addr == end_r)));
  assign take   = ending && q_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      end_r    <= '0;
      seg_done <= 1'b0;
      irq      <= 1'b0;
    end else begin
      seg_done <= 1'b0;
      irq      <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            cur_addr <= start_addr;
            end_r    <= end_addr;
            state    <= ST_RUN;
          end
        end
        default: begin
          if (ending) begin
            seg_done <= 1'b1;
            if (q_full) begin
              cur_addr <= q_first;
              end_r    <= q_last;
            end else begin
              state <= ST_IDLE;
              irq   <= 1'b1;
            end
          end else if (row_adv) begin
            cur_addr <= nxt_addr;
          end
        end
      endcase
    end
  end

  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && seg_done));
  // R9
  chain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ending && q_full) |=> (busy && seg_done && !irq));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_req) |=> $stable(cur_addr));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && row_adv && !ending && cur_addr == TOP_ROW) |=> (cur_addr == WRAP_ROW));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && row_adv && !ending && cur_addr != TOP_ROW) |=> (cur_addr == $past(cur_addr) + 1'b1));
endmodule

// File: rtl/play_addr_seq.sv
`timescale 1ns/1ps
module play_addr_seq #(
  parameter int unsigned ROW_W     = play_seq_pkg::DEF_ROW_W,
  parameter int unsigned WRAP_BASE = play_seq_pkg::DEF_WRAP_BASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [ROW_W-1:0] start_addr,
  input  logic [ROW_W-1:0] end_addr,
  input  logic             preload_stb,
  input  logic [ROW_W-1:0] preload_start,
  input  logic [ROW_W-1:0] preload_end,
  input  logic             row_adv,
  input  logic             eom,
  input  logic             stop_on_eom,
  output logic [ROW_W-1:0] cur_addr,
  output logic             busy,
  output logic             ready,
  output logic             seg_done,
  output logic             irq,
  output logic             queued
);
  logic [ROW_W-1:0] q_first;
  logic [ROW_W-1:0] q_last;
  logic [ROW_W-1:0] nxt_addr;
  logic             take;

  row_stepper #(.ROW_W(ROW_W), .WRAP_BASE(WRAP_BASE)) u_step (
    .cur (cur_addr),
    .nxt (nxt_addr)
  );

  pair_slot #(.ROW_W(ROW_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (preload_stb),
    .take      (take),
    .in_first  (preload_start),
    .in_last   (preload_end),
    .out_first (q_first),
    .out_last  (q_last),
    .full      (queued)
  );

  seg_control #(.ROW_W(ROW_W), .WRAP_BASE(WRAP_BASE)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .start_addr  (start_addr),
    .end_addr    (end_addr),
    .row_adv     (row_adv),
    .eom         (eom),
    .stop_on_eom (stop_on_eom),
    .q_full      (queued),
    .q_first     (q_first),
    .q_last      (q_last),
    .nxt_addr    (nxt_addr),
    .cur_addr    (cur_addr),
    .busy        (busy),
    .take        (take),
    .seg_done    (seg_done),
    .irq         (irq)
  );

  assign ready = !busy;
endmodule

// File: tb/test_play_addr_seq.sv
`timescale 1ns/1ps
module test_play_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic [10:0] start_addr = '0;
  logic [10:0] end_addr = '0;
  logic        preload_stb = 1'b0;
  logic [10:0] preload_start = '0;
  logic [10:0] preload_end = '0;
  logic        row_adv = 1'b0;
  logic        eom = 1'b0;
  logic        stop_on_eom = 1'b0;
  logic [10:0] cur_addr;
  logic        busy, ready, seg_done, irq, queued;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  play_addr_seq i_play_addr_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_addr(start_addr),
    .end_addr(end_addr), .preload_stb(preload_stb), .preload_start(preload_start),
    .preload_end(preload_end), .row_adv(row_adv), .eom(eom), .stop_on_eom(stop_on_eom),
    .cur_addr(cur_addr), .busy(busy), .ready(ready), .seg_done(seg_done),
    .irq(irq), .queued(queued)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cur = 0, m_end = 0, m_busy = 0, m_seg = 0, m_irq = 0;
  int qs[$];
  int qe[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_end = 0; m_busy = 0; m_seg = 0; m_irq = 0;
      qs.delete(); qe.delete();
    end else begin
      int fin;
      fin = m_busy && (stop_on_eom ? eom : (row_adv && m_cur == m_end));
      m_seg = 0; m_irq = 0;
      if (!m_busy) begin
        if (start_req) begin
          m_cur = start_addr; m_end = end_addr; m_busy = 1;
        end
      end else if (fin) begin
        m_seg = 1;
        if (qs.size() > 0) begin
          m_cur = qs.pop_front(); m_end = qe.pop_front();
        end else begin
          m_busy = 0; m_irq = 1;
        end
      end else if (row_adv) begin
        m_cur = (m_cur == 2047) ? 16 : m_cur + 1;
      end
      if (preload_stb) begin
        qs.delete(); qe.delete();
        qs.push_back(preload_start); qe.push_back(preload_end);
      end
    end
  end

  always begin
    @(posedge clk);
    #1;
    chk("R3 cur_addr", cur_addr, m_cur);
    chk("R2 busy", busy, m_busy);
    chk("R10 ready", ready, !m_busy);
    chk("R9 seg_done", seg_done, m_seg);
    chk("R10 irq", irq, m_irq);
    chk("R8 queued", queued, qs.size() != 0);
  end

  task automatic adv();
    @(negedge clk) row_adv = 1'b1;
    @(negedge clk) row_adv = 1'b0;
  endtask

  task automatic go(input int s, input int e);
    @(negedge clk) begin start_req = 1'b1; start_addr = 11'(s); end_addr = 11'(e); end
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic pre(input int s, input int e);
    @(negedge clk) begin preload_stb = 1'b1; preload_start = 11'(s); preload_end = 11'(e); end
    @(negedge clk) preload_stb = 1'b0;
  endtask

  task automatic marker();
    @(negedge clk) eom = 1'b1;
    @(negedge clk) eom = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cur_addr", cur_addr, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ready", ready, 1);
    chk("R1 irq", irq, 0);
    chk("R1 queued", queued, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2, R3, R5: plain segment
    go(12'h100, 12'h103);
    chk("R2 start loads", cur_addr, 'h100);
    chk("R2 busy after start", busy, 1);
    adv();
    go(12'h050, 12'h060);
    chk("R2 start while busy ignored", cur_addr, 'h101);
    adv(); adv();
    chk("R3 increments", cur_addr, 'h103);
    adv();
    chk("R5 end row played then stop", busy, 0);
    chk("R10 irq pulse", irq, 1);
    @(negedge clk);
    chk("R10 irq one cycle", irq, 0);

    // R4, R5: wrap past reserved rows
    go(12'h7FE, 12'h011);
    adv(); adv();
    chk("R4 wrap to 0x010", cur_addr, 'h010);
    adv();
    chk("R5 after wrap", cur_addr, 'h011);
    adv();
    chk("R5 wrapped segment ends", busy, 0);

    // R6 endless run, then R7 marker stop
    go(12'h7FE, 12'h005);
    for (int i = 0; i < 4200; i++) adv();
    chk("R6 never ends", busy, 1);
    stop_on_eom = 1'b1;
    marker();
    chk("R7 marker ends run", busy, 0);
    chk("R7 irq on marker", irq, 1);

    // R7 end row ignored in marker mode
    go(12'h200, 12'h200);
    for (int i = 0; i < 5; i++) adv();
    chk("R7 end row ignored", cur_addr, 'h205);
    chk("R7 still busy", busy, 1);
    marker();
    chk("R7 stop", busy, 0);
    stop_on_eom = 1'b0;

    // R8, R9 chaining with overwrite
    go(12'h300, 12'h301);
    pre(12'h400, 12'h401);
    pre(12'h500, 12'h502);
    chk("R8 queued set", queued, 1);
    adv();
    adv();
    chk("R9 seamless jump", cur_addr, 'h500);
    chk("R9 still busy", busy, 1);
    chk("R9 seg_done", seg_done, 1);
    chk("R9 no irq", irq, 0);
    chk("R8 queue consumed", queued, 0);
    adv(); adv();
    chk("R9 queued end used", cur_addr, 'h502);
    adv();
    chk("R10 chain end", busy, 0);
    chk("R10 chain irq", irq, 1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule